// File: doc/BRIEF.md
# Hardware Semaphore and Lock Unit

This unit lets several processors synchronise on shared state without software spin loops on memory. It holds a small bank of semaphores and a separate bank of one-bit locks. Every requester presents one operation at a time on a plain request/grant interface. It holds the request until a one-cycle grant pulse answers it, and then takes the request away or replaces it in the cycle that pulse is visible. A wait (P) on a semaphore whose count is zero is not refused. It stays pending and drops out of arbitration until some other requester signals that semaphore. A lock acquire never waits. It is answered at once, and a fail flag tells the requester to try again.

All requesters share one arbitrated commit path, so exactly one operation changes state per clock, and each operation is indivisible as seen by every other requester. Each semaphore is configured by parameter as binary or counting, and it has a configured reset value. A parameter mask also places chosen binary semaphores in a split group. At most one member of that group may hold 1 at any time.

Top module: `semlock_unit`

## Requirements
- R1: After synchronous reset, grant, fail and err are all 0, every lock is free, and each semaphore holds its configured initial value (default build: semaphores 0 to 4 hold 1, except semaphore 3 which holds 3; semaphores 5 to 7 hold 0).
- R2: An operation is encoded on two bits per requester: 0 = wait (P), 1 = signal (V), 2 = lock acquire, 3 = lock release. A P on a semaphore with a count above zero decrements the count and is granted. A P on a count of zero gets no grant and stays pending until the count becomes non-zero.
- R3: A V is always granted. When it is accepted, the count rises by one and err stays 0.
- R4: A V on a binary semaphore (COUNT_MASK bit 0) that already holds 1 leaves it at 1 and raises err for that requester together with its grant. A binary semaphore never holds more than 1.
- R5: A counting semaphore (COUNT_MASK bit 1) never exceeds MAXV (default 5; semaphores 2 and 3 are counting). A V at MAXV leaves the count unchanged and raises err with the grant.
- R6: For members of the split group (SPLIT_MASK, default semaphores 4 to 7), a V on a member while another member holds 1 is rejected. The value stays unchanged and err is raised with the grant, so at most one member ever holds 1.
- R7: A lock acquire is granted in any case. If the lock (numbered by the low two bits of the index) was free it becomes held and fail is 0. If it was held it stays held and fail is 1 with the grant.
- R8: A lock release is granted and leaves the lock free, whatever its previous state.
- R9: At most one grant bit is high in any cycle.
- R10: When several requests are eligible, the winner is the first eligible requester at or after the one following the previous winner, in rising index order with wrap-around. A pending P on a zero count is not eligible, so every pending request is eventually served.
- R11: A request that is eligible and has no competitor is committed on the next clock edge. Its grant is visible in the cycle after the request was first presented, and a grant never appears without a request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Per-requester request pending |
| req_op | input | 2*N_REQ | Per-requester operation code, 2 bits each |
| req_idx | input | SW*N_REQ | Per-requester semaphore number; low bits give the lock number |
| grant | output | N_REQ | One-cycle completion pulse, registered |
| fail | output | N_REQ | Lock acquire found the lock held; valid with grant |
| err | output | N_REQ | V saturated or was rejected; valid with grant |

## Verification
The hard cases are arbitration and the availability of a semaphore changing in the same cycle. A V commits and makes a stalled P on that semaphore eligible on the very next edge, where it competes with fresh requests for the round-robin slot. The bench provokes this by holding a P on an empty semaphore while the other requesters keep issuing mixed waits, signals, acquires and releases on the same resources. A behavioural model predicts, for every clock, the winner, the new counts and the err and fail flags. It compares all three outputs every cycle, so a grant given out of turn or one cycle late is reported against the arbitration or latency requirement.

// File: rtl/semlock_pkg.sv
package semlock_pkg;
  typedef enum logic [1:0] {
    OP_DOWN = 2'd0,
    OP_UP   = 2'd1,
    OP_TAKE = 2'd2,
    OP_DROP = 2'd3
  } sl_op_e;
endpackage

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
  parameter int N = 4,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  output logic          win_valid,
  output logic [RW-1:0] win_idx
);
  logic [RW-1:0] ptr_q;

  // scan from the pointer upward; the lowest offset found is kept
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (elig[j]) begin
        win_valid = 1'b1;
        win_idx   = RW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (win_valid) ptr_q <= (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int VW = 4,
  parameter int MAXV = 5,
  parameter logic [NSEM-1:0] COUNT_MASK = 8'h0C,
  parameter logic [NSEM-1:0] SPLIT_MASK = 8'hF0,
  parameter logic [NSEM*VW-1:0] INIT_VALS = 32'h0001_3111,
  localparam int SW = (NSEM > 1) ? $clog2(NSEM) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic               op_down,
  input  logic               op_up,
  input  logic [SW-1:0]      op_idx,
  output logic               v_err,
  output logic [NSEM-1:0]    nz,
  output logic [NSEM*VW-1:0] vals_flat
);
  logic [VW-1:0] val_q [NSEM];
  logic [VW-1:0] cur, limit;
  logic          others_one;

  assign cur   = val_q[op_idx];
  assign limit = COUNT_MASK[op_idx] ? VW'(MAXV) : VW'(1);

  always_comb begin
    others_one = 1'b0;
    for (int s = 0; s < NSEM; s++)
      if (SPLIT_MASK[s] && (SW'(s) != op_idx) && (val_q[s] != '0)) others_one = 1'b1;
  end

  assign v_err = op_valid && op_up &&
                 ((cur >= limit) || (SPLIT_MASK[op_idx] && others_one));

  for (genvar s = 0; s < NSEM; s++) begin : g_view
    assign nz[s] = |val_q[s];
    assign vals_flat[s*VW +: VW] = val_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSEM; s++) val_q[s] <= INIT_VALS[s*VW +: VW];
    end else if (op_valid && op_down && (cur != '0)) begin
      val_q[op_idx] <= cur - 1'b1;
    end else if (op_valid && op_up && !v_err) begin
      val_q[op_idx] <= cur + 1'b1;
    end
  end
endmodule

// File: rtl/lock_bank.sv
module lock_bank #(
  parameter int NLOCK = 4,
  localparam int LW = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_take,
  input  logic          op_drop,
  input  logic [LW-1:0] op_idx,
  output logic          busy
);
  logic [NLOCK-1:0] held_q;

  assign busy = held_q[op_idx];

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else if (op_valid) begin
      if (op_take && !busy) held_q[op_idx] <= 1'b1;
      else if (op_drop) held_q[op_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/semlock_unit.sv
module semlock_unit
  import semlock_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int NSEM = 8,
  parameter int NLOCK = 4,
  parameter int VW = 4,
  parameter int MAXV = 5,
  parameter logic [NSEM-1:0] COUNT_MASK = 8'h0C,
  parameter logic [NSEM-1:0] SPLIT_MASK = 8'hF0,
  parameter logic [NSEM*VW-1:0] INIT_VALS = 32'h0001_3111,
  localparam int SW = (NSEM > 1) ? $clog2(NSEM) : 1,
  localparam int LW = (NLOCK > 1) ? $clog2(NLOCK) : 1,
  localparam int RW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_REQ-1:0]    req_valid,
  input  logic [2*N_REQ-1:0]  req_op,
  input  logic [SW*N_REQ-1:0] req_idx,
  output logic [N_REQ-1:0]    grant,
  output logic [N_REQ-1:0]    fail,
  output logic [N_REQ-1:0]    err
);
  logic [NSEM-1:0]    sem_nz;
  logic [NSEM*VW-1:0] sem_vals;
  logic [N_REQ-1:0]   elig;
  logic               win_valid;
  logic [RW-1:0]      win_idx;
  sl_op_e             w_op;
  logic [SW-1:0]      w_idx;
  logic [N_REQ-1:0]   w_oh;
  logic               do_down, do_up, do_take, do_drop;
  logic               v_err, lock_busy;

  // a wait on an empty semaphore stays out of arbitration
  for (genvar i = 0; i < N_REQ; i++) begin : g_elig
    logic [1:0]    op_i;
    logic [SW-1:0] idx_i;
    assign op_i    = req_op[2*i +: 2];
    assign idx_i   = req_idx[SW*i +: SW];
    assign elig[i] = req_valid[i] && ((op_i != OP_DOWN) || sem_nz[idx_i]);
  end

  sem_rr_arb #(.N(N_REQ)) u_arb (
    .clk(clk), .rst(rst), .elig(elig), .win_valid(win_valid), .win_idx(win_idx)
  );

  always_comb begin
    w_op  = sl_op_e'(req_op[2*int'(win_idx) +: 2]);
    w_idx = req_idx[SW*int'(win_idx) +: SW];
    w_oh  = N_REQ'(1) << win_idx;
  end

  assign do_down = win_valid && (w_op == OP_DOWN);
  assign do_up   = win_valid && (w_op == OP_UP);
  assign do_take = win_valid && (w_op == OP_TAKE);
  assign do_drop = win_valid && (w_op == OP_DROP);

  sem_bank #(
    .NSEM(NSEM), .VW(VW), .MAXV(MAXV), .COUNT_MASK(COUNT_MASK),
    .SPLIT_MASK(SPLIT_MASK), .INIT_VALS(INIT_VALS)
  ) u_sems (
    .clk(clk), .rst(rst), .op_valid(win_valid), .op_down(do_down), .op_up(do_up),
    .op_idx(w_idx), .v_err(v_err), .nz(sem_nz), .vals_flat(sem_vals)
  );

  lock_bank #(.NLOCK(NLOCK)) u_locks (
    .clk(clk), .rst(rst), .op_valid(win_valid), .op_take(do_take), .op_drop(do_drop),
    .op_idx(w_idx[LW-1:0]), .busy(lock_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= '0;
      fail  <= '0;
      err   <= '0;
    end else begin
      grant <= win_valid ? w_oh : '0;
      err   <= v_err ? w_oh : '0;
      fail  <= (do_take && lock_busy) ? w_oh : '0;
    end
  end
endmodule

// File: rtl/semlock_chk.sv
module semlock_chk #(
  parameter int N_REQ = 4,
  parameter int NSEM = 8,
  parameter int VW = 4,
  parameter int MAXV = 5,
  parameter logic [NSEM-1:0] COUNT_MASK = 8'h0C,
  parameter logic [NSEM-1:0] SPLIT_MASK = 8'hF0
) (
  input logic               clk,
  input logic               rst,
  input logic [N_REQ-1:0]   req_valid,
  input logic [2*N_REQ-1:0] req_op,
  input logic [N_REQ-1:0]   grant,
  input logic [N_REQ-1:0]   fail,
  input logic [N_REQ-1:0]   err,
  input logic [NSEM*VW-1:0] vals_flat
);
  logic [N_REQ-1:0] up_m, take_m;
  logic [NSEM-1:0]  split_one, bin_bad, cnt_bad;

  for (genvar i = 0; i < N_REQ; i++) begin : g_ops
    assign up_m[i]   = req_valid[i] && (req_op[2*i +: 2] == 2'd1);
    assign take_m[i] = req_valid[i] && (req_op[2*i +: 2] == 2'd2);
  end

  for (genvar s = 0; s < NSEM; s++) begin : g_vals
    assign split_one[s] = SPLIT_MASK[s] && (vals_flat[s*VW +: VW] != '0);
    assign bin_bad[s]   = !COUNT_MASK[s] && (vals_flat[s*VW +: VW] > VW'(1));
    assign cnt_bad[s]   = COUNT_MASK[s] && (vals_flat[s*VW +: VW] > VW'(MAXV));
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R9
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (grant & ~$past(req_valid)) == '0); // R11
  AST_ERR_ON_SIGNAL: assert property (@(posedge clk) disable iff (rst)
    (err & ~(grant & $past(up_m))) == '0); // R4
  AST_FAIL_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    (fail & ~(grant & $past(take_m))) == '0); // R7
  AST_SPLIT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones(split_one) <= 1); // R6
  AST_BIN_RANGE: assert property (@(posedge clk) disable iff (rst) bin_bad == '0); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_bad == '0); // R5
endmodule

bind semlock_unit semlock_chk #(
  .N_REQ(N_REQ), .NSEM(NSEM), .VW(VW), .MAXV(MAXV),
  .COUNT_MASK(COUNT_MASK), .SPLIT_MASK(SPLIT_MASK)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .grant(grant), .fail(fail), .err(err), .vals_flat(sem_vals)
);

// File: tb/sim_semlock_unit.sv
module sim_semlock_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, NS = 8, NL = 4, VW = 4, MAXV = 5, SW = 3, QCAP = 128;
  localparam logic [NS-1:0] CNT = 8'h0C, SPL = 8'hF0;
  localparam logic [NS*VW-1:0] INIT = 32'h0001_3111;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_op = '0;
  logic [SW*N-1:0] req_idx = '0;
  logic [N-1:0] grant, fail, err;

  semlock_unit u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
                   .req_idx(req_idx), .grant(grant), .fail(fail), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int sop [N][QCAP], sidx [N][QCAP];
  int head [N], tail [N];
  int mval [NS], mlock [NL], fresh [NS];
  int mptr;
  int ecount = 0, fcount = 0;
  logic [N-1:0] exp_grant, exp_fail, exp_err;
  string exp_tag;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int r, int op, int idx);
    sop[r][tail[r]] = op;
    sidx[r][tail[r]] = idx;
    tail[r]++;
  endtask

  function automatic bit all_empty();
    for (int r = 0; r < N; r++) if (head[r] != tail[r]) return 0;
    return 1;
  endfunction

  task automatic drain();
    int c = 0;
    while (!all_empty() && c < 2000) begin @(negedge clk); c++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // driver, per-cycle comparison and behavioural model
  always @(negedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin mval[s] = int'(INIT[s*VW +: VW]); fresh[s] = 1; end
      for (int l = 0; l < NL; l++) mlock[l] = 0;
      mptr = 0;
      exp_grant = '0; exp_fail = '0; exp_err = '0; exp_tag = "R1";
      req_valid = '0;
    end else begin
      int w, nelig;
      chk(grant === exp_grant, exp_tag, int'(grant), int'(exp_grant));
      chk(err === exp_err, exp_tag, int'(err), int'(exp_err));
      chk(fail === exp_fail, exp_tag, int'(fail), int'(exp_fail));
      chk($countones(grant) <= 1, "R9", int'(grant), 0);
      ecount += $countones(err);
      fcount += $countones(fail);
      for (int r = 0; r < N; r++) if (grant[r] && head[r] < tail[r]) head[r]++;
      for (int r = 0; r < N; r++) begin
        req_valid[r] = (head[r] < tail[r]);
        req_op[2*r +: 2] = 2'(sop[r][head[r]]);
        req_idx[SW*r +: SW] = SW'(sidx[r][head[r]]);
      end
      w = -1; nelig = 0;
      for (int k = 0; k < N; k++) begin
        int j, op, ix;
        j = (mptr + k) % N;
        op = sop[j][head[j]]; ix = sidx[j][head[j]];
        if (req_valid[j] && (op != 0 || mval[ix] > 0)) begin
          nelig++;
          if (w < 0) w = j;
        end
      end
      exp_grant = '0; exp_fail = '0; exp_err = '0; exp_tag = "R10";
      if (w >= 0) begin
        int op, ix, lim, oth;
        op = sop[w][head[w]]; ix = sidx[w][head[w]];
        mptr = (w + 1) % N;
        exp_grant[w] = 1'b1;
        case (op)
          0: begin mval[ix]--; exp_tag = fresh[ix] ? "R1" : "R2"; fresh[ix] = 0; end
          1: begin
            lim = CNT[ix] ? MAXV : 1; oth = 0;
            for (int s = 0; s < NS; s++) if (SPL[s] && s != ix && mval[s] > 0) oth = 1;
            if (mval[ix] >= lim) begin exp_err[w] = 1'b1; exp_tag = CNT[ix] ? "R5" : "R4"; end
            else if (SPL[ix] && oth != 0) begin exp_err[w] = 1'b1; exp_tag = "R6"; end
            else begin mval[ix]++; exp_tag = "R3"; end
            fresh[ix] = 0;
          end
          2: begin
            if (mlock[ix % NL] != 0) exp_fail[w] = 1'b1; else mlock[ix % NL] = 1;
            exp_tag = "R7";
          end
          default: begin mlock[ix % NL] = 0; exp_tag = "R8"; end
        endcase
        if (nelig > 1) exp_tag = {exp_tag, "/R10"};
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e0, f0;
    for (int r = 0; r < N; r++) begin head[r] = 0; tail[r] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(grant == '0 && err == '0 && fail == '0, "R1", int'({grant, err, fail}), 0);

    // R11: lone wait on semaphore 0 (holds 1) granted after one edge
    @(posedge clk); #1 push(0, 0, 0);
    @(negedge clk); @(negedge clk); #1;
    chk(grant[0] == 1'b1, "R11", int'(grant), 1);
    drain();

    // R2: wait on empty semaphore 0 stalls until a signal arrives
    push(1, 0, 0);
    repeat (6) @(negedge clk); #1;
    chk(grant[1] == 1'b0 && head[1] != tail[1], "R2", int'(grant), 0);
    push(2, 1, 0);
    drain();
    chk(head[1] == tail[1], "R2", head[1], tail[1]);

    // R4: signal on binary semaphore 1 already at 1
    e0 = ecount; push(0, 1, 1); drain();
    chk(ecount - e0 == 1, "R4", ecount - e0, 1);

    // R5: counting semaphore 3 starts at 3; third signal hits the maximum
    e0 = ecount;
    push(0, 1, 3); push(0, 1, 3); push(0, 1, 3);
    drain();
    chk(ecount - e0 == 1, "R5", ecount - e0, 1);
    for (int k = 0; k < 6; k++) push(1, 0, 3);
    repeat (20) @(negedge clk); #1;
    chk(tail[1] - head[1] == 1, "R5", tail[1] - head[1], 1);
    push(2, 1, 3); drain();

    // R6: split group, semaphore 4 holds 1
    e0 = ecount;
    push(0, 1, 5); drain();
    push(1, 0, 4); push(2, 1, 5); drain();
    push(3, 1, 6); drain();
    chk(ecount - e0 == 2, "R6", ecount - e0, 2);

    // R7 and R8: lock 1 acquire, contended acquire, release, reacquire
    f0 = fcount;
    push(0, 2, 1); drain();
    push(1, 2, 1); drain();
    chk(fcount - f0 == 1, "R7", fcount - f0, 1);
    push(2, 3, 1); drain();
    push(1, 2, 1); push(3, 3, 2); drain();
    chk(fcount - f0 == 1, "R8", fcount - f0, 1);

    // R10: all requesters contend on one counting semaphore and two locks
    for (int rep = 0; rep < 6; rep++)
      for (int r = 0; r < N; r++) begin
        push(r, 0, 2); push(r, 1, 2);
        push(r, 2, r % 2); push(r, 3, (r + rep) % 2);
      end
    drain();
    chk(all_empty(), "R10", 0, 1);

    finish_run();
  end
endmodule